// File: doc/BRIEF.md
# External Memory Bus Master with Hold Handshake

This block is the engine a serial link controller uses to move buffer words between itself and shared system memory. An internal client presents one transfer at a time: an address, a direction, a width flag, write data and a flag that marks the last transfer of a burst. Before any memory cycle, the block asks the host processor for the system bus with a hold request. It touches no bus pin until the host returns hold acknowledge. It then runs one or more memory cycles and hands the bus back after the last transfer of the burst.

Each memory cycle begins with an address phase. The 24-bit address is split: bits 0 to 15 have their own pins, and bits 16 to 23 go out on the pins that later carry the upper data byte, where an external latch catches them on an address strobe pulse. An address-enable output is high for the whole time the block owns the bus. It gates the latched upper address onto the system bus and keeps other drivers off. The read or write strobe is then held low for a minimum number of clocks, and for longer while the memory holds its ready input low. A static width pin selects an 8-bit or a 16-bit data bus. On the 16-bit bus an upper-byte-enable output, together with address bit 0, tells the memory which byte lanes are valid.

Tri-state pins appear as a value output plus an output enable, so a pad ring can add the buffers.

Top module: `membus_master`

## Requirements
- R1: While reset is asserted, hold_req, aen, astb, bus_oe, ube_oe and done are all 0.
- R2: After a request arrives, hold_req rises, and bus_oe and aen stay 0 until hold_ack has been sampled high. The first address phase follows the clock edge at which hold_ack is seen high.
- R3: Each transfer has exactly one clock of astb = 1. In that clock, aen = 1, ad_hi_oe = 1, ad_hi_o equals address bits 23..16 and addr_lo equals address bits 15..0.
- R4: While a read strobe is low, ad_hi_oe and d_lo_oe are both 0, so the memory can drive both data lanes.
- R5: aen is 1 exactly while the block owns the bus, and it is never 1 unless hold_req is also 1.
- R6: A read or write strobe stays low for STRB_CYC clocks (default 2) when ready is high. Each clock in which ready is sampled low after the minimum width adds one clock of strobe low time.
- R7: With bw_sel = 0 (8-bit bus), ube_oe stays 0, every transfer uses only the low lane (write data bits 7..0 on d_lo_o), and read data returns as {8'h00, d_lo_i}.
- R8: With bw_sel = 1 (16-bit bus), ube_n follows address bit 0 and the width flag. An even address with req_word = 1 gives ube_n = 0 with both lanes, and read data {ad_hi_i, d_lo_i}. An even address with req_word = 0 gives ube_n = 1 with the low lane only. An odd address gives ube_n = 0 with the high lane only: write byte bits 7..0 go out on ad_hi_o, and the read byte returns in rd_data bits 7..0 with the upper bits zero.
- R9: After a done for a transfer with req_last = 0, hold_req stays 1 and the bus is kept. After a done for a transfer with req_last = 1, the next clock has hold_req = 0, aen = 0 and bus_oe = 0.
- R10: rd_data holds the read value captured at the clock edge that ends the strobe, and it is valid from the done clock onward.
- R11: done is a single-clock pulse, one for each transfer.
- R12: rd_n and wr_n are never low together, and only the strobe that matches the transfer direction goes low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| req_valid | input | 1 | Transfer request, held until done |
| req_addr | input | 24 | Byte address of the transfer |
| req_write | input | 1 | 1 = write, 0 = read |
| req_word | input | 1 | 1 = 16-bit transfer (16-bit bus, even address) |
| req_last | input | 1 | Marks the last transfer of a burst |
| req_wdata | input | 16 | Write data; a byte transfer uses bits 7..0 |
| rd_data | output | 16 | Read data, right-aligned for byte reads |
| done | output | 1 | One-clock pulse when a transfer completes |
| bw_sel | input | 1 | Static bus width: 0 = 8-bit, 1 = 16-bit |
| hold_req | output | 1 | Bus request to the host |
| hold_ack | input | 1 | Bus grant from the host |
| aen | output | 1 | Address enable, high while bus owner |
| astb | output | 1 | Address strobe for the external upper-address latch |
| bus_oe | output | 1 | Enable for the address pins 0..15 and both strobes |
| addr_lo | output | 16 | Address bits 15..0 |
| ad_hi_o | output | 8 | Shared pins: address 23..16, then upper data byte |
| ad_hi_oe | output | 1 | Output enable of the shared pins |
| ad_hi_i | input | 8 | Input value of the shared pins |
| d_lo_o | output | 8 | Low data lane output |
| d_lo_oe | output | 1 | Low data lane output enable |
| d_lo_i | input | 8 | Low data lane input |
| ube_n | output | 1 | Upper byte enable, active low |
| ube_oe | output | 1 | Upper byte enable output enable |
| rd_n | output | 1 | Memory read strobe, active low |
| wr_n | output | 1 | Memory write strobe, active low |
| ready | input | 1 | Memory ready; low extends the strobe |

## Verification
A corrupt sequencer state shows at the pins within one clock. The strobe is then too short or never ends, astb appears twice or not at all, or aen rises before the grant. Each of these is visible on the next sampled clock. A wrong captured lane shows on ube_n and on the data-lane enables during the first strobe clock, and as misplaced bytes in rd_data at done. A lost burst-end flag shows as hold_req still high, or already low, in the clock after done. The bench therefore samples these pins in every clock of every transfer and does not only compare final data.

// File: rtl/membus_pkg.sv
package membus_pkg;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_HOLD_REQ,
    SQ_ADDR,
    SQ_STROBE,
    SQ_WAIT,
    SQ_DONE,
    SQ_RELEASE
  } sq_state_e;

  typedef enum logic [1:0] {
    LN_LOW,
    LN_HIGH,
    LN_BOTH
  } lane_e;

  // Byte lanes used by one transfer, from bus width, width flag and address bit 0.
  function automatic lane_e pick_lane(input logic wide_bus, input logic wide_req,
                                      input logic a0);
    lane_e l;
    if (!wide_bus)     l = LN_LOW;
    else if (a0)       l = LN_HIGH;
    else if (wide_req) l = LN_BOTH;
    else               l = LN_LOW;
    return l;
  endfunction

  function automatic logic owns_bus(input sq_state_e s);
    return (s == SQ_ADDR) || (s == SQ_STROBE) || (s == SQ_WAIT) || (s == SQ_DONE);
  endfunction

  function automatic logic data_phase(input sq_state_e s);
    return (s == SQ_STROBE) || (s == SQ_WAIT) || (s == SQ_DONE);
  endfunction

  function automatic logic strobe_low(input sq_state_e s);
    return (s == SQ_STROBE) || (s == SQ_WAIT);
  endfunction

endpackage

// File: rtl/membus_seq.sv
module membus_seq
  import membus_pkg::*;
#(
  parameter int STRB_CYC = 2
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      req_valid,
  input  logic      req_last,
  input  logic      hold_ack,
  input  logic      ready,
  output sq_state_e state_o,
  output logic      capture_o,
  output logic      sample_o,
  output logic      done_o
);

  localparam int CNT_W = (STRB_CYC > 2) ? $clog2(STRB_CYC) : 1;
  localparam logic [CNT_W-1:0] CNT_END = CNT_W'(STRB_CYC - 2);

  sq_state_e        state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;
  logic             last_q;
  logic             dwell_q, dwell_d;
  logic             capture;

  always_comb begin
    state_d = state_q;
    capture = 1'b0;
    cnt_d   = cnt_q;
    cnt_en  = 1'b0;
    unique case (state_q)
      SQ_IDLE: begin
        if (req_valid) begin
          capture = 1'b1;
          state_d = SQ_HOLD_REQ;
        end
      end
      SQ_HOLD_REQ: begin
        if (hold_ack) state_d = SQ_ADDR;
      end
      SQ_ADDR: begin
        cnt_d   = '0;
        cnt_en  = 1'b1;
        state_d = SQ_STROBE;
      end
      SQ_STROBE: begin
        if (cnt_q == CNT_END) begin
          state_d = SQ_WAIT;
        end else begin
          cnt_d  = cnt_q + 1'b1;
          cnt_en = 1'b1;
        end
      end
      SQ_WAIT: begin
        if (ready) state_d = SQ_DONE;
      end
      SQ_DONE: begin
        if (last_q) begin
          state_d = SQ_RELEASE;
        end else if (dwell_q && req_valid) begin
          capture = 1'b1;
          state_d = SQ_ADDR;
        end
      end
      SQ_RELEASE: begin
        if (!hold_ack) state_d = SQ_IDLE;
      end
      default: state_d = SQ_IDLE;
    endcase
  end

  assign dwell_d = (state_q == SQ_DONE) && (state_d == SQ_DONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SQ_IDLE;
      dwell_q <= 1'b0;
    end else begin
      state_q <= state_d;
      dwell_q <= dwell_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       last_q <= 1'b0;
    else if (capture) last_q <= req_last;
  end

  assign state_o   = state_q;
  assign capture_o = capture;
  assign sample_o  = (state_q == SQ_WAIT) && ready;
  assign done_o    = (state_q == SQ_DONE) && !dwell_q;

endmodule

// File: rtl/membus_lanes.sv
module membus_lanes
  import membus_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int LANE_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  sq_state_e           state,
  input  logic                capture,
  input  logic                sample,
  input  logic                bw_sel,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic                req_write,
  input  logic                req_word,
  input  logic [2*LANE_W-1:0] req_wdata,
  input  logic [LANE_W-1:0]   ad_hi_i,
  input  logic [LANE_W-1:0]   d_lo_i,
  output logic [ADDR_W-LANE_W-1:0] addr_lo,
  output logic [LANE_W-1:0]   ad_hi_o,
  output logic                ad_hi_oe,
  output logic [LANE_W-1:0]   d_lo_o,
  output logic                d_lo_oe,
  output logic                ube_n,
  output logic                ube_oe,
  output logic                rd_n,
  output logic                wr_n,
  output logic [2*LANE_W-1:0] rd_data
);

  localparam int LO_W   = ADDR_W - LANE_W;
  localparam int DATA_W = 2 * LANE_W;

  logic [ADDR_W-1:0] addr_q;
  logic              wr_q;
  lane_e             lane_q;
  logic [DATA_W-1:0] wdata_q;
  logic [DATA_W-1:0] rd_q, rd_d;
  logic              rd_en;
  logic              lo_used, hi_used;
  logic              wr_drive;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wr_q    <= 1'b0;
      lane_q  <= LN_LOW;
      wdata_q <= '0;
    end else if (capture) begin
      addr_q  <= req_addr;
      wr_q    <= req_write;
      lane_q  <= pick_lane(bw_sel, req_word, req_addr[0]);
      wdata_q <= req_wdata;
    end
  end

  assign lo_used  = (lane_q != LN_HIGH);
  assign hi_used  = (lane_q != LN_LOW);
  assign wr_drive = data_phase(state) && wr_q;

  // Read data steering into a right-aligned result.
  always_comb begin
    rd_en = sample && !wr_q;
    unique case (lane_q)
      LN_BOTH: rd_d = {ad_hi_i, d_lo_i};
      LN_HIGH: rd_d = {{LANE_W{1'b0}}, ad_hi_i};
      default: rd_d = {{LANE_W{1'b0}}, d_lo_i};
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rd_q <= '0;
    else if (rd_en) rd_q <= rd_d;
  end

  // Shared upper pins: address during the address phase, then data or float.
  always_comb begin
    ad_hi_o  = '0;
    ad_hi_oe = 1'b0;
    if (state == SQ_ADDR) begin
      ad_hi_o  = addr_q[ADDR_W-1 -: LANE_W];
      ad_hi_oe = 1'b1;
    end else if (wr_drive && hi_used) begin
      ad_hi_o  = (lane_q == LN_BOTH) ? wdata_q[DATA_W-1:LANE_W] : wdata_q[LANE_W-1:0];
      ad_hi_oe = 1'b1;
    end
  end

  assign addr_lo = addr_q[LO_W-1:0];
  assign d_lo_o  = wr_drive && lo_used ? wdata_q[LANE_W-1:0] : '0;
  assign d_lo_oe = wr_drive && lo_used;
  assign ube_oe  = owns_bus(state) && bw_sel;
  assign ube_n   = (lane_q == LN_LOW);
  assign rd_n    = !(strobe_low(state) && !wr_q);
  assign wr_n    = !(strobe_low(state) && wr_q);
  assign rd_data = rd_q;

endmodule

// File: rtl/membus_master.sv
module membus_master
  import membus_pkg::*;
#(
  parameter int ADDR_W   = 24,
  parameter int LANE_W   = 8,
  parameter int STRB_CYC = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  input  logic [ADDR_W-1:0]        req_addr,
  input  logic                     req_write,
  input  logic                     req_word,
  input  logic                     req_last,
  input  logic [2*LANE_W-1:0]      req_wdata,
  output logic [2*LANE_W-1:0]      rd_data,
  output logic                     done,
  input  logic                     bw_sel,
  output logic                     hold_req,
  input  logic                     hold_ack,
  output logic                     aen,
  output logic                     astb,
  output logic                     bus_oe,
  output logic [ADDR_W-LANE_W-1:0] addr_lo,
  output logic [LANE_W-1:0]        ad_hi_o,
  output logic                     ad_hi_oe,
  input  logic [LANE_W-1:0]        ad_hi_i,
  output logic [LANE_W-1:0]        d_lo_o,
  output logic                     d_lo_oe,
  input  logic [LANE_W-1:0]        d_lo_i,
  output logic                     ube_n,
  output logic                     ube_oe,
  output logic                     rd_n,
  output logic                     wr_n,
  input  logic                     ready
);

  sq_state_e state;
  logic      capture;
  logic      sample;

  membus_seq #(.STRB_CYC(STRB_CYC)) i_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_last  (req_last),
    .hold_ack  (hold_ack),
    .ready     (ready),
    .state_o   (state),
    .capture_o (capture),
    .sample_o  (sample),
    .done_o    (done)
  );

  membus_lanes #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) i_lanes (
    .clk       (clk),
    .rst_n     (rst_n),
    .state     (state),
    .capture   (capture),
    .sample    (sample),
    .bw_sel    (bw_sel),
    .req_addr  (req_addr),
    .req_write (req_write),
    .req_word  (req_word),
    .req_wdata (req_wdata),
    .ad_hi_i   (ad_hi_i),
    .d_lo_i    (d_lo_i),
    .addr_lo   (addr_lo),
    .ad_hi_o   (ad_hi_o),
    .ad_hi_oe  (ad_hi_oe),
    .d_lo_o    (d_lo_o),
    .d_lo_oe   (d_lo_oe),
    .ube_n     (ube_n),
    .ube_oe    (ube_oe),
    .rd_n      (rd_n),
    .wr_n      (wr_n),
    .rd_data   (rd_data)
  );

  assign hold_req = (state != SQ_IDLE) && (state != SQ_RELEASE);
  assign aen      = owns_bus(state);
  assign bus_oe   = owns_bus(state);
  assign astb     = (state == SQ_ADDR);

endmodule

// File: rtl/membus_master_chk.sv
module membus_master_chk (
  input logic clk,
  input logic rst_n,
  input logic hold_req,
  input logic hold_ack,
  input logic aen,
  input logic astb,
  input logic bus_oe,
  input logic rd_n,
  input logic wr_n,
  input logic ready,
  input logic ad_hi_oe,
  input logic d_lo_oe,
  input logic ube_oe,
  input logic bw_sel,
  input logic done
);

  logic any_strb_n;
  assign any_strb_n = rd_n & wr_n;

  // R2: bus ownership starts only after a sampled grant
  p_grant_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_oe) |-> $past(hold_ack) && $past(hold_req));

  // R5: address enable only while requesting the bus
  p_aen_needs_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    aen |-> hold_req);

  // R3: address strobe is a single clock and comes with address enable
  p_astb_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    astb |=> !astb);
  p_astb_aen_r3: assert property (@(posedge clk) disable iff (!rst_n)
    astb |-> aen && ad_hi_oe);

  // R4: both data lanes float during a read strobe
  p_read_float_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_n |-> !ad_hi_oe && !d_lo_oe);

  // R6: minimum strobe width and stretch while not ready
  p_strobe_min_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(any_strb_n) |=> !any_strb_n);
  p_strobe_stretch_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!any_strb_n && $past(!any_strb_n) && !ready) |=> !any_strb_n);

  // R7: upper byte enable floats on the 8-bit bus
  p_ube_float_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !bw_sel |-> !ube_oe);

  // R11: completion is a single-clock pulse
  p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R12: strobes are mutually exclusive and only active while owning the bus
  p_strobe_excl_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({~rd_n, ~wr_n}) <= 1);
  p_strobe_owner_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !any_strb_n |-> bus_oe);

endmodule

bind membus_master membus_master_chk i_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .hold_req (hold_req),
  .hold_ack (hold_ack),
  .aen      (aen),
  .astb     (astb),
  .bus_oe   (bus_oe),
  .rd_n     (rd_n),
  .wr_n     (wr_n),
  .ready    (ready),
  .ad_hi_oe (ad_hi_oe),
  .d_lo_oe  (d_lo_oe),
  .ube_oe   (ube_oe),
  .bw_sel   (bw_sel),
  .done     (done)
);

// File: tb/test_membus_master.sv
`timescale 1ns/1ps
module test_membus_master;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_write, req_word, req_last;
  logic [23:0] req_addr;
  logic [15:0] req_wdata;
  logic [15:0] rd_data;
  logic        done, bw_sel, hold_req, hold_ack, aen, astb, bus_oe;
  logic [15:0] addr_lo;
  logic [7:0]  ad_hi_o, ad_hi_i, d_lo_o, d_lo_i;
  logic        ad_hi_oe, d_lo_oe, ube_n, ube_oe, rd_n, wr_n, ready;

  int errors = 0;
  int checks = 0;

  always #2 clk = ~clk;

  membus_master i_membus_master (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_write(req_write), .req_word(req_word), .req_last(req_last),
    .req_wdata(req_wdata), .rd_data(rd_data), .done(done), .bw_sel(bw_sel),
    .hold_req(hold_req), .hold_ack(hold_ack), .aen(aen), .astb(astb),
    .bus_oe(bus_oe), .addr_lo(addr_lo), .ad_hi_o(ad_hi_o), .ad_hi_oe(ad_hi_oe),
    .ad_hi_i(ad_hi_i), .d_lo_o(d_lo_o), .d_lo_oe(d_lo_oe), .d_lo_i(d_lo_i),
    .ube_n(ube_n), .ube_oe(ube_oe), .rd_n(rd_n), .wr_n(wr_n), .ready(ready)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One complete transfer with per-clock observation of the pins.
  task automatic xfer(input logic [23:0] a, input logic w, input logic wd,
                      input logic [15:0] wdata, input logic last,
                      input int waits, input int ack_dly,
                      input logic [7:0] lo_in, input logic [7:0] hi_in,
                      input logic [15:0] exp_rd,
                      input logic exp_lo_oe, input logic exp_hi_oe,
                      input logic [7:0] exp_lo, input logic [7:0] exp_hi,
                      input logic exp_ube_oe, input logic exp_ube_n,
                      input string lane_req);
    int cyc = 0, ack_cnt = 0, astb_n = 0, low = 0, early = 0, wrong = 0, lane_bad = 0;
    logic addr_ok = 1'b1;
    logic seen = 1'b0;
    @(negedge clk);
    req_addr = a; req_write = w; req_word = wd; req_wdata = wdata; req_last = last;
    d_lo_i = lo_in; ad_hi_i = hi_in; req_valid = 1'b1;
    while (!seen && cyc < 300) begin
      @(negedge clk);
      cyc++;
      if (hold_req && !hold_ack) begin
        if (bus_oe || aen) early++;
        ack_cnt++;
        if (ack_cnt > ack_dly) hold_ack = 1'b1;
      end
      if (astb) begin
        astb_n++;
        if (!aen || !ad_hi_oe || ad_hi_o !== a[23:16] || addr_lo !== a[15:0]) addr_ok = 1'b0;
      end
      if ((w && !rd_n) || (!w && !wr_n)) wrong++;
      if ((w && !wr_n) || (!w && !rd_n)) begin
        low++;
        ready = (low >= 2 + waits);
        if (d_lo_oe !== exp_lo_oe || ad_hi_oe !== exp_hi_oe) lane_bad++;
        if (exp_lo_oe && d_lo_o !== exp_lo) lane_bad++;
        if (exp_hi_oe && ad_hi_o !== exp_hi) lane_bad++;
        if (ube_oe !== exp_ube_oe || (exp_ube_oe && ube_n !== exp_ube_n)) lane_bad++;
      end
      if (done) begin
        seen = 1'b1;
        req_valid = 1'b0;
        ready = 1'b1;
      end
    end
    check({"R11 done seen ", lane_req}, 32'(seen), 32'd1);
    check("R2 no drive before grant", early, 0);
    check("R3 one address strobe", astb_n, 1);
    check("R3 address phase contents", 32'(addr_ok), 32'd1);
    check("R12 strobe direction", wrong, 0);
    check("R6 strobe low width", low, 2 + waits);
    check({lane_req, " lanes and byte enable"}, lane_bad, 0);
    @(negedge clk);
    check("R11 done single clock", 32'(done), 32'd0);
    if (!w) check({"R10 read data ", lane_req}, 32'(rd_data), 32'(exp_rd));
    if (last) begin
      check("R9 bus released after last", {29'd0, hold_req, aen, bus_oe}, 32'd0);
      hold_ack = 1'b0;
      @(negedge clk);
    end else begin
      check("R9 bus kept inside burst", {30'd0, hold_req, aen}, 32'd3);
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 reset outputs", {26'd0, hold_req, aen, astb, bus_oe, ube_oe, done}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 idle after reset", {30'd0, hold_req, aen}, 32'd0);
  endtask

  task automatic t_byte_bus();
    bw_sel = 1'b0;
    // R7: odd address on the 8-bit bus still uses the low lane
    xfer(24'h5A1233, 1'b1, 1'b1, 16'hBEEF, 1'b1, 0, 0, 8'h00, 8'h00, 16'h0000,
         1'b1, 1'b0, 8'hEF, 8'h00, 1'b0, 1'b0, "R7 byte write");
    xfer(24'h5A1233, 1'b0, 1'b1, 16'h0000, 1'b1, 0, 2, 8'h3C, 8'hA5, 16'h003C,
         1'b0, 1'b0, 8'h00, 8'h00, 1'b0, 1'b0, "R7 byte read");
  endtask

  task automatic t_word_lanes();
    bw_sel = 1'b1;
    xfer(24'h123456, 1'b1, 1'b1, 16'hCAFE, 1'b1, 0, 0, 8'h00, 8'h00, 16'h0000,
         1'b1, 1'b1, 8'hFE, 8'hCA, 1'b1, 1'b0, "R8 word write");
    xfer(24'h123456, 1'b0, 1'b1, 16'h0000, 1'b1, 0, 0, 8'h11, 8'h22, 16'h2211,
         1'b0, 1'b0, 8'h00, 8'h00, 1'b1, 1'b0, "R8 R4 word read");
    xfer(24'h123458, 1'b1, 1'b0, 16'h9977, 1'b1, 0, 0, 8'h00, 8'h00, 16'h0000,
         1'b1, 1'b0, 8'h77, 8'h00, 1'b1, 1'b1, "R8 even byte write");
    xfer(24'h123458, 1'b0, 1'b0, 16'h0000, 1'b1, 0, 0, 8'h44, 8'h55, 16'h0044,
         1'b0, 1'b0, 8'h00, 8'h00, 1'b1, 1'b1, "R8 even byte read");
    xfer(24'h123459, 1'b1, 1'b0, 16'h9977, 1'b1, 0, 0, 8'h00, 8'h00, 16'h0000,
         1'b0, 1'b1, 8'h00, 8'h77, 1'b1, 1'b0, "R8 odd byte write");
    xfer(24'h123459, 1'b0, 1'b0, 16'h0000, 1'b1, 0, 0, 8'h44, 8'h55, 16'h0055,
         1'b0, 1'b0, 8'h00, 8'h00, 1'b1, 1'b0, "R8 odd byte read");
  endtask

  task automatic t_wait_states();
    bw_sel = 1'b1;
    // R6: three clocks of ready low stretch the strobe to five clocks
    xfer(24'hF00010, 1'b0, 1'b1, 16'h0000, 1'b1, 3, 1, 8'h6B, 8'h9D, 16'h9D6B,
         1'b0, 1'b0, 8'h00, 8'h00, 1'b1, 1'b0, "R6 waited read");
    xfer(24'hF00012, 1'b1, 1'b1, 16'h1357, 1'b1, 1, 0, 8'h00, 8'h00, 16'h0000,
         1'b1, 1'b1, 8'h57, 8'h13, 1'b1, 1'b0, "R6 waited write");
  endtask

  task automatic t_burst();
    bw_sel = 1'b1;
    // R9: three transfers under one grant
    xfer(24'h0A0000, 1'b1, 1'b1, 16'h0102, 1'b0, 0, 3, 8'h00, 8'h00, 16'h0000,
         1'b1, 1'b1, 8'h02, 8'h01, 1'b1, 1'b0, "R9 burst first");
    xfer(24'h0A0002, 1'b0, 1'b1, 16'h0000, 1'b0, 1, 0, 8'h0D, 8'h0C, 16'h0C0D,
         1'b0, 1'b0, 8'h00, 8'h00, 1'b1, 1'b0, "R9 burst second");
    xfer(24'h0A0005, 1'b1, 1'b0, 16'h00EE, 1'b1, 0, 0, 8'h00, 8'h00, 16'h0000,
         1'b0, 1'b1, 8'h00, 8'hEE, 1'b1, 1'b0, "R9 burst last");
  endtask

  initial begin
    req_valid = 1'b0; req_write = 1'b0; req_word = 1'b0; req_last = 1'b0;
    req_addr = '0; req_wdata = '0; bw_sel = 1'b0; hold_ack = 1'b0;
    ready = 1'b1; ad_hi_i = '0; d_lo_i = '0; rst_n = 1'b0;
    t_reset();
    t_byte_bus();
    t_word_lanes();
    t_wait_states();
    t_burst();
    repeat (2) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule